// File: doc/BRIEF.md
# Word-Serial Modular Adder/Subtractor

This block computes `(a + b) mod q` or `(a - b) mod q` for wide operands that arrive one word per cycle, least significant word first. The modulus `q` is a fixed parameter; the default is the 256-bit prime 2^256 - 2^224 + 2^192 + 2^96 - 1, split into eight 32-bit words. Both operands are assumed to already be reduced below `q`.

As each word pair arrives, two carry chains run side by side. One chain forms the raw sum or difference. The other chain applies the correction by `q` to the same partial result: it subtracts `q` for addition and adds `q` for subtraction. Both candidate results are kept in word buffers. After the last word, the final carry and borrow flags pick one of the two candidates, so the block needs no magnitude compare and no second pass.

The chosen result is then streamed out, least significant word first. `done_o` marks the first output word.

Top module: `modq_addsub_serial`

## Requirements
- R1: After reset, `done_o` is 0 and `result_o` is 0.
- R2: With `op_sub_i` = 0 at start, the streamed result equals (a + b) mod q for any a, b < q.
- R3: With `op_sub_i` = 1 at start, the streamed result equals (a - b) mod q for any a, b < q.
- R4: Addition boundaries are handled. If a + b = q, the result is 0. If a + b = 2q - 2, the result is q - 2.
- R5: Subtraction boundaries are handled. If a = b, the result is 0. If a = 0 and b = q - 1, the result is 1.
- R6: Input and output timing:
  - Word 0 of each operand is sampled on the edge where `start_i` is seen while idle, and words 1 to NUM_WORDS-1 are sampled on the following edges.
  - `done_o` is a one-cycle pulse in the cycle after the last word is sampled.
  - The result words appear on `result_o` over NUM_WORDS consecutive cycles, least significant first. The first word appears in the `done_o` cycle.
- R7: `start_i` is ignored while words are being taken in or while the result is being streamed out.
- R8: `result_o` is 0 whenever no result is being streamed.
- R9: The operation is taken from `op_sub_i` only on the start edge. Changes to `op_sub_i` during the rest of the operation have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin an operation; word 0 is present on the operand inputs in the same cycle |
| op_sub_i | input | 1 | 0 = add, 1 = subtract; sampled with start |
| a_word_i | input | WORD_W | Current word of operand a |
| b_word_i | input | WORD_W | Current word of operand b |
| result_o | output | WORD_W | Current result word while streaming, else 0 |
| done_o | output | 1 | One-cycle pulse that marks result word 0 |

## Verification
The assertions take for granted that the operand words keep the agreed cadence: one word pair on each consecutive cycle from the start cycle on, with no gaps. The assertions make no claim about values; only the bench comparison checks that operands below q give a result below q. The bench draws random words from $urandom and folds any value of q or more back below q before use, so every operand it drives is already reduced. It deliberately toggles `op_sub_i` and `start_i` in the middle of operations, to confirm that these inputs are ignored there.

// File: rtl/modq_addsub_serial.sv
module modq_addsub_serial #(
  parameter int WORD_W    = 32,
  parameter int NUM_WORDS = 8,
  parameter logic [WORD_W*NUM_WORDS-1:0] MODULUS =
    256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              op_sub_i,
  input  logic [WORD_W-1:0] a_word_i,
  input  logic [WORD_W-1:0] b_word_i,
  output logic [WORD_W-1:0] result_o,
  output logic              done_o
);
  localparam int CNT_W = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NUM_WORDS - 1);

  typedef enum logic [1:0] {ST_IDLE, ST_IN, ST_OUT} state_t;
  state_t state;

  logic [CNT_W-1:0]  cnt;
  logic              op_q, cy_q, bw_q, use_raw;
  logic [WORD_W-1:0] raw_buf [NUM_WORDS];
  logic [WORD_W-1:0] cor_buf [NUM_WORDS];
  logic [WORD_W-1:0] q_arr   [NUM_WORDS];

  for (genvar g = 0; g < NUM_WORDS; g++) begin : g_qword
    assign q_arr[g] = MODULUS[g*WORD_W +: WORD_W];
  end

  logic              accept, op_eff, cy_in, bw_in, cyo, bwo, sel_raw;
  logic [WORD_W:0]   s1, s2;
  logic [WORD_W-1:0] raw_w, cor_w;

  assign accept = (state == ST_IDLE && start_i) || state == ST_IN;
  assign op_eff = (state == ST_IDLE) ? op_sub_i : op_q;
  assign cy_in  = (state == ST_IDLE) ? 1'b0 : cy_q;
  assign bw_in  = (state == ST_IDLE) ? 1'b0 : bw_q;

  always_comb begin
    if (!op_eff) begin
      s1 = {1'b0, a_word_i} + {1'b0, b_word_i} + {{WORD_W{1'b0}}, cy_in};
      s2 = {1'b0, s1[WORD_W-1:0]} - {1'b0, q_arr[cnt]} - {{WORD_W{1'b0}}, bw_in};
      cyo = s1[WORD_W];
      bwo = s2[WORD_W];
    end else begin
      s1 = {1'b0, a_word_i} - {1'b0, b_word_i} - {{WORD_W{1'b0}}, bw_in};
      s2 = {1'b0, s1[WORD_W-1:0]} + {1'b0, q_arr[cnt]} + {{WORD_W{1'b0}}, cy_in};
      bwo = s1[WORD_W];
      cyo = s2[WORD_W];
    end
    raw_w   = s1[WORD_W-1:0];
    cor_w   = s2[WORD_W-1:0];
    sel_raw = op_eff ? !bwo : (bwo && !cyo);
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      raw_buf[cnt] <= raw_w;
      cor_buf[cnt] <= cor_w;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      op_q    <= 1'b0;
      cy_q    <= 1'b0;
      bw_q    <= 1'b0;
      use_raw <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start_i) begin
          op_q  <= op_sub_i;
          cy_q  <= cyo;
          bw_q  <= bwo;
          cnt   <= cnt + 1'b1;
          state <= ST_IN;
        end
        ST_IN: begin
          cy_q <= cyo;
          bw_q <= bwo;
          if (cnt == LAST) begin
            use_raw <= sel_raw;
            cnt     <= '0;
            state   <= ST_OUT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_OUT: begin
          if (cnt == LAST) begin
            cnt   <= '0;
            state <= ST_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign result_o = (state == ST_OUT) ? (use_raw ? raw_buf[cnt] : cor_buf[cnt]) : '0;
  assign done_o   = (state == ST_OUT) && (cnt == '0);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(state == ST_IN)); // R6
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (result_o == '0 && !done_o)); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IN && cnt != LAST) |=> (state == ST_IN && cnt == $past(cnt) + 1'b1)); // R7
  AST_OP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state != ST_IDLE) |=> $stable(op_q)); // R9
endmodule

// File: tb/test_modq_addsub_serial.sv
module test_modq_addsub_serial;
  localparam int CLK_PERIOD = 10;
  localparam int W = 32;
  localparam int N = 8;
  localparam int TW = W * N;
  localparam logic [TW-1:0] Q =
    256'hFFFFFFFF_00000001_00000000_00000000_00000000_FFFFFFFF_FFFFFFFF_FFFFFFFF;

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, op_sub_i = 1'b0;
  logic [W-1:0] a_word_i = '0, b_word_i = '0;
  logic [W-1:0] result_o;
  logic done_o;
  int n_checks = 0, n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  modq_addsub_serial #(.WORD_W(W), .NUM_WORDS(N), .MODULUS(Q)) i_modq_addsub_serial (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_sub_i(op_sub_i),
    .a_word_i(a_word_i), .b_word_i(b_word_i), .result_o(result_o), .done_o(done_o));

  function automatic logic [TW-1:0] ref_add(logic [TW-1:0] a, logic [TW-1:0] b);
    logic [TW:0] s = {1'b0, a} + {1'b0, b};
    if (s >= {1'b0, Q}) s = s - {1'b0, Q};
    return s[TW-1:0];
  endfunction

  function automatic logic [TW-1:0] ref_sub(logic [TW-1:0] a, logic [TW-1:0] b);
    logic [TW:0] d;
    if (a >= b) d = {1'b0, a} - {1'b0, b};
    else        d = {1'b0, a} + {1'b0, Q} - {1'b0, b};
    return d[TW-1:0];
  endfunction

  function automatic logic [TW-1:0] rand_reduced();
    logic [TW-1:0] v;
    for (int k = 0; k < N; k++) v[k*W +: W] = $urandom;
    if (v >= Q) v = v - Q;
    return v;
  endfunction

  task automatic chk(bit ok, string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_op(bit sub, logic [TW-1:0] a, logic [TW-1:0] b, string req);
    logic [TW-1:0] exp, got;
    int dones;
    exp = sub ? ref_sub(a, b) : ref_add(a, b);
    got = '0;
    dones = 0;
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      start_i  = (k == 0) || (k == 3);  // R7: restart attempt mid-input
      op_sub_i = (k == 0) ? sub : ~sub; // R9: op flips after start
      a_word_i = a[k*W +: W];
      b_word_i = b[k*W +: W];
    end
    for (int k = 0; k < N; k++) begin
      @(negedge clk);
      start_i  = (k == N-1);            // R7: start during output phase
      op_sub_i = ~sub;
      a_word_i = $urandom;
      b_word_i = $urandom;
      if (k == 0) chk(done_o == 1'b1, "R6 done with word 0", {255'b0, done_o}, 1);
      dones += int'(done_o);
      got[k*W +: W] = result_o;
    end
    chk(dones == 1, "R6 single done pulse", dones, 1);
    chk(got == exp, req, got, exp);
    @(negedge clk);
    start_i = 1'b0;
    chk(result_o == '0 && !done_o, "R8/R7 idle after stream",
        {223'b0, done_o, result_o}, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(!done_o && result_o == '0, "R1 reset state", {223'b0, done_o, result_o}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!done_o && result_o == '0, "R1 after reset", {223'b0, done_o, result_o}, 0);

    run_op(1'b0, 256'd123, Q - 256'd123, "R4 a+b=q");
    run_op(1'b0, Q - 256'd1, Q - 256'd1, "R4 a+b=2q-2");
    run_op(1'b0, '0, '0, "R2 zero add");
    run_op(1'b1, Q - 256'd7, Q - 256'd7, "R5 a=b");
    run_op(1'b1, '0, Q - 256'd1, "R5 a=0 b=q-1");
    run_op(1'b1, Q - 256'd1, '0, "R3 q-1 minus 0");
    for (int i = 0; i < 20; i++) begin
      logic [TW-1:0] ra, rb;
      ra = rand_reduced();
      rb = rand_reduced();
      run_op(1'b0, ra, rb, "R2 random add");
      run_op(1'b1, ra, rb, "R3 random sub");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule